// File: doc/BRIEF.md
# External Interrupt Wake Controller

This block sits beside the core's interrupt logic and handles two external request pins: a maskable one, gated by an enable bit, and a nonmaskable one. Each pin passes through a synchronizer. It is then sampled only in the second phase of the two-phase state clock, which the block receives as a phase indicator. Qualifying edges set a pending flag for each source. Each flag stays set until the core acknowledges it.

The block also decides how the core leaves a low-power mode. From idle, a rising edge on the nonmaskable pin brings the core back, as does a rising edge on the maskable pin when that interrupt is enabled. In both cases the handler runs first. From powerdown, only a high level on the maskable pin brings the core back, and it does so whether the interrupt is enabled or not. A handler is requested only when the interrupt is enabled; otherwise the core simply resumes. The nonmaskable pin has no effect in powerdown. The wake output is a single-cycle pulse, and a qualifier tells the core whether to run a handler or resume. A registered service request presents the pending source with its vector address. The nonmaskable source is presented first.

Top module: `xint_wake_ctrl`

## Requirements
- R1: Synchronous active-high reset clears all outputs: ext_pend, nmi_pend, svc_req, svc_nmi, svc_vec (to 0), wake and run_handler.
- R2: Each pin passes through a two-stage synchronizer and is then sampled only in cycles where ph2 is 1. A high level that reaches the synchronizer output only in a cycle with ph2 at 0 is ignored. The same level reaching it in a cycle with ph2 at 1 is captured.
- R3: In normal mode (pwr_mode 2'b00, with 2'b11 treated the same) and in idle mode (2'b01), a sampled rising edge on ext_pin sets ext_pend whatever the value of ext_en.
- R4: In idle mode, a sampled rising edge on ext_pin produces a wake pulse with run_handler 1 when ext_en is 1. It produces no wake when ext_en is 0.
- R5: In powerdown mode (2'b10), a high ext_pin level at a phase-2 sample produces a wake pulse whatever the value of ext_en. run_handler equals ext_en, and ext_pend is set only when ext_en is 1.
- R6: In normal or idle mode, a sampled rising edge on nmi_pin sets nmi_pend. Its service request carries the vector 0x203E.
- R7: In idle mode, a sampled rising edge on nmi_pin produces a wake pulse with run_handler 1.
- R8: In powerdown mode, nmi_pin produces no wake and does not set nmi_pend.
- R9: A pending flag stays set until its acknowledge input is 1 at a clock edge. A set condition in the same cycle as the acknowledge leaves the flag set.
- R10: One cycle after the pending flags, svc_req is registered as nmi_pend OR (ext_pend AND ext_en). When nmi_pend is set, svc_nmi is 1 and svc_vec is 0x203E. When only the enabled maskable request is present, svc_vec is 0x200C. With no request, svc_vec is 0.
- R11: wake is never high in two consecutive cycles. run_handler is high only together with wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Maskable external interrupt pin, asynchronous |
| nmi_pin | input | 1 | Nonmaskable interrupt pin, asynchronous |
| ext_en | input | 1 | Enable for the maskable interrupt |
| pwr_mode | input | 2 | 00 normal, 01 idle, 10 powerdown, 11 as normal |
| ph2 | input | 1 | High in state-clock phase 2 cycles |
| ext_ack | input | 1 | Clears ext_pend |
| nmi_ack | input | 1 | Clears nmi_pend |
| ext_pend | output | 1 | Maskable interrupt pending |
| nmi_pend | output | 1 | Nonmaskable interrupt pending |
| svc_req | output | 1 | Service request |
| svc_nmi | output | 1 | Request is the nonmaskable source |
| svc_vec | output | VEC_W | Vector address of the request |
| wake | output | 1 | Single-cycle wake pulse |
| run_handler | output | 1 | With wake: 1 run handler, 0 resume |

## Verification
The assertions assume that reset is held for at least one clock edge before checking begins. They also assume that pwr_mode returns to normal in the cycle after a wake pulse, since a powerdown level held in a mode that never changes would otherwise wake again two cycles later. The stimulus changes every input on the falling edge. It drops pwr_mode to normal as soon as it sees wake, and it produces ph2 as a strict alternation. Pin pulses last several cycles, except the deliberate single-cycle pulses aimed at a known phase.

// File: rtl/xwk_pkg.sv
package xwk_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_IDLE   = 2'b01,
    PM_PDOWN  = 2'b10,
    PM_RSVD   = 2'b11
  } pmode_e;

  localparam int SRC_EXT = 0;
  localparam int SRC_NMI = 1;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/xwk_pin_sampler.sv
module xwk_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic ph2,
  output logic smp_level,
  output logic smp_rise
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] chain;
  logic         prev_q;
  logic         sync_out;

  assign sync_out = chain[TOP];

  // metastability chain: shifts every clock
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[TOP-1:0], pin};
  end

  // previous sample only advances on phase-2 sample points
  always_ff @(posedge clk) begin
    if (rst)      prev_q <= 1'b0;
    else if (ph2) prev_q <= sync_out;
  end

  assign smp_level = ph2 & sync_out;
  assign smp_rise  = ph2 & sync_out & ~prev_q;
endmodule

// File: rtl/xwk_pend_flag.sv
module xwk_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic pend
);
  // set has priority over acknowledge
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= set | (pend & ~ack);
  end
endmodule

// File: rtl/xwk_wake_ctl.sv
module xwk_wake_ctl
  import xwk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  pmode_e mode,
  input  logic   ext_en,
  input  logic   ext_level,
  input  logic   ext_rise,
  input  logic   nmi_rise,
  output logic   ext_set,
  output logic   nmi_set,
  output logic   wake,
  output logic   run_handler
);
  logic wake_cond;
  logic hndl_cond;

  always_comb begin
    ext_set   = 1'b0;
    nmi_set   = 1'b0;
    wake_cond = 1'b0;
    hndl_cond = 1'b0;
    unique case (mode)
      PM_IDLE: begin
        ext_set   = ext_rise;
        nmi_set   = nmi_rise;
        wake_cond = nmi_rise | (ext_rise & ext_en);
        hndl_cond = 1'b1;
      end
      PM_PDOWN: begin
        // level wake, independent of enable; nonmaskable pin ignored
        ext_set   = ext_level & ext_en;
        nmi_set   = 1'b0;
        wake_cond = ext_level;
        hndl_cond = ext_en;
      end
      default: begin
        ext_set   = ext_rise;
        nmi_set   = nmi_rise;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake        <= 1'b0;
      run_handler <= 1'b0;
    end else begin
      wake        <= wake_cond & ~wake;
      run_handler <= wake_cond & ~wake & hndl_cond;
    end
  end
endmodule

// File: rtl/xwk_svc_arb.sv
module xwk_svc_arb #(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h203E,
  parameter logic [VEC_W-1:0] EXT_VEC = 16'h200C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pend,
  input  logic             nmi_pend,
  input  logic             ext_en,
  output logic             svc_req,
  output logic             svc_nmi,
  output logic [VEC_W-1:0] svc_vec
);
  logic ext_live;
  assign ext_live = ext_pend & ext_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_req <= 1'b0;
      svc_nmi <= 1'b0;
      svc_vec <= '0;
    end else begin
      svc_req <= nmi_pend | ext_live;
      svc_nmi <= nmi_pend;
      if (nmi_pend)      svc_vec <= NMI_VEC;
      else if (ext_live) svc_vec <= EXT_VEC;
      else               svc_vec <= '0;
    end
  end
endmodule

// File: rtl/xint_wake_ctrl.sv
module xint_wake_ctrl
  import xwk_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               VEC_W       = 16,
  parameter logic [VEC_W-1:0] NMI_VEC     = 16'h203E,
  parameter logic [VEC_W-1:0] EXT_VEC     = 16'h200C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             nmi_pin,
  input  logic             ext_en,
  input  logic [1:0]       pwr_mode,
  input  logic             ph2,
  input  logic             ext_ack,
  input  logic             nmi_ack,
  output logic             ext_pend,
  output logic             nmi_pend,
  output logic             svc_req,
  output logic             svc_nmi,
  output logic [VEC_W-1:0] svc_vec,
  output logic             wake,
  output logic             run_handler
);
  logic [NUM_SRC-1:0] pins;
  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] setv;
  logic [NUM_SRC-1:0] ackv;
  logic [NUM_SRC-1:0] pendv;
  logic               ext_set;
  logic               nmi_set;
  logic               ext_level;
  pmode_e             mode;

  assign mode              = pmode_e'(pwr_mode);
  assign pins[SRC_EXT]     = ext_pin;
  assign pins[SRC_NMI]     = nmi_pin;
  assign ackv[SRC_EXT]     = ext_ack;
  assign ackv[SRC_NMI]     = nmi_ack;
  assign setv[SRC_EXT]     = ext_set;
  assign setv[SRC_NMI]     = nmi_set;
  assign ext_level         = lvl[SRC_EXT];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    xwk_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk      (clk),
      .rst      (rst),
      .pin      (pins[s]),
      .ph2      (ph2),
      .smp_level(lvl[s]),
      .smp_rise (rise[s])
    );
    xwk_pend_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (setv[s]),
      .ack (ackv[s]),
      .pend(pendv[s])
    );
  end

  xwk_wake_ctl u_wake (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .ext_en     (ext_en),
    .ext_level  (ext_level),
    .ext_rise   (rise[SRC_EXT]),
    .nmi_rise   (rise[SRC_NMI]),
    .ext_set    (ext_set),
    .nmi_set    (nmi_set),
    .wake       (wake),
    .run_handler(run_handler)
  );

  assign ext_pend = pendv[SRC_EXT];
  assign nmi_pend = pendv[SRC_NMI];

  xwk_svc_arb #(
    .VEC_W  (VEC_W),
    .NMI_VEC(NMI_VEC),
    .EXT_VEC(EXT_VEC)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .ext_pend(ext_pend),
    .nmi_pend(nmi_pend),
    .ext_en  (ext_en),
    .svc_req (svc_req),
    .svc_nmi (svc_nmi),
    .svc_vec (svc_vec)
  );
endmodule

// File: rtl/xwk_chk.sv
module xwk_chk #(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h203E
) (
  input logic             clk,
  input logic             rst,
  input logic             ph2,
  input logic [1:0]       pwr_mode,
  input logic             ext_ack,
  input logic             ext_pend,
  input logic             nmi_pend,
  input logic             svc_req,
  input logic             svc_nmi,
  input logic [VEC_W-1:0] svc_vec,
  input logic             wake,
  input logic             run_handler,
  input logic             ext_set,
  input logic             ext_level
);
  assert_phase_only_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!ph2 && !ext_pend) |-> !ext_pend);

  assert_pd_level_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (wake && $past(pwr_mode) == 2'b10) |-> $past(ext_level));

  assert_idle_handler_R7: assert property (@(posedge clk) disable iff (rst)
    (wake && $past(pwr_mode) == 2'b01) |-> run_handler);

  assert_pd_nmi_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_mode == 2'b10 && !nmi_pend) |-> !nmi_pend);

  assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ext_set) |-> ext_pend);

  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ext_pend && !ext_ack) |-> ext_pend);

  assert_nmi_first_R10: assert property (@(posedge clk) disable iff (rst)
    $past(nmi_pend) |-> (svc_req && svc_nmi && svc_vec == NMI_VEC));

  assert_wake_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);

  assert_handler_qual_R11: assert property (@(posedge clk) disable iff (rst)
    run_handler |-> wake);
endmodule

bind xint_wake_ctrl xwk_chk #(
  .VEC_W  (VEC_W),
  .NMI_VEC(NMI_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ph2        (ph2),
  .pwr_mode   (pwr_mode),
  .ext_ack    (ext_ack),
  .ext_pend   (ext_pend),
  .nmi_pend   (nmi_pend),
  .svc_req    (svc_req),
  .svc_nmi    (svc_nmi),
  .svc_vec    (svc_vec),
  .wake       (wake),
  .run_handler(run_handler),
  .ext_set    (ext_set),
  .ext_level  (ext_level)
);

// File: tb/tb_xint_wake_ctrl.sv
`timescale 1ns/1ps
module tb_xint_wake_ctrl;
  localparam logic [15:0] NMI_V = 16'h203E;
  localparam logic [15:0] EXT_V = 16'h200C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_pin = 1'b0, nmi_pin = 1'b0, ext_en = 1'b0;
  logic [1:0]  pwr_mode = 2'b00;
  logic        ph2 = 1'b0, ext_ack = 1'b0, nmi_ack = 1'b0;
  logic        ext_pend, nmi_pend, svc_req, svc_nmi, wake, run_handler;
  logic [15:0] svc_vec;

  int n_checks = 0;
  int n_fail   = 0;
  int wake_cnt = 0;
  int hnd_seen = 0;
  int pend_cnt = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  xint_wake_ctrl dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .nmi_pin(nmi_pin),
    .ext_en(ext_en), .pwr_mode(pwr_mode), .ph2(ph2),
    .ext_ack(ext_ack), .nmi_ack(nmi_ack), .ext_pend(ext_pend),
    .nmi_pend(nmi_pend), .svc_req(svc_req), .svc_nmi(svc_nmi),
    .svc_vec(svc_vec), .wake(wake), .run_handler(run_handler)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: sample at falling edge, react, then advance phase
  task automatic tick();
    @(negedge clk);
    if (wake) begin
      wake_cnt++;
      if (run_handler) hnd_seen = 1;
      pwr_mode = 2'b00;
    end
    if (ext_pend) pend_cnt++;
    ph2 = ~ph2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; ext_pin = 0; nmi_pin = 0; ext_ack = 0; nmi_ack = 0;
    pwr_mode = 2'b00; ext_en = 0;
    ticks(3);
    rst = 1'b0;
    wake_cnt = 0; hnd_seen = 0; pend_cnt = 0;
  endtask

  task automatic run_trial(input int src, input int mode, input int en);
    bit ee, is_pd, is_idle;
    int e_wake, e_hnd, e_ep, e_np, e_req, e_vec;
    do_reset();
    pwr_mode = mode[1:0];
    ext_en   = en[0];
    ticks(2);
    if (src == 0) ext_pin = 1; else nmi_pin = 1;
    ticks(4);
    ext_pin = 0; nmi_pin = 0;
    ticks(8);
    ee      = (src == 0);
    is_pd   = (mode == 2);
    is_idle = (mode == 1);
    e_wake  = ee ? (is_pd ? 1 : (is_idle ? en : 0)) : (is_idle ? 1 : 0);
    e_hnd   = (e_wake != 0) ? ((ee && is_pd) ? en : 1) : 0;
    e_ep    = ee ? (is_pd ? en : 1) : 0;
    e_np    = (!ee && !is_pd) ? 1 : 0;
    e_req   = (e_np != 0 || (e_ep != 0 && en != 0)) ? 1 : 0;
    e_vec   = (e_np != 0) ? int'(NMI_V) : ((e_req != 0) ? int'(EXT_V) : 0);
    check("R3 R5 ext_pend", int'(ext_pend), e_ep);
    check("R6 R8 nmi_pend", int'(nmi_pend), e_np);
    check("R4 R5 R7 R8 R11 wake count", wake_cnt, e_wake);
    check("R4 R5 R7 run_handler", hnd_seen, e_hnd);
    check("R10 svc_req", int'(svc_req), e_req);
    check("R6 R10 svc_vec", int'(svc_vec), e_vec);
  endtask

  initial begin
    // R1: outputs during and after reset, with pins pulled high meanwhile
    rst = 1'b1; ext_pin = 1; nmi_pin = 1;
    ticks(4);
    check("R1 reset outputs",
          int'({ext_pend, nmi_pend, svc_req, svc_nmi, wake, run_handler}), 0);
    check("R1 reset vector", int'(svc_vec), 0);

    // exhaustive sweep: source x mode x enable
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          run_trial(s, m, e);

    // R2: one-cycle pulse placed in a phase-1 interval is missed
    do_reset();
    ticks(2);
    while (ph2 != 1'b0) tick();
    ext_pin = 1; tick(); ext_pin = 0;
    ticks(6);
    check("R2 phase-1 pulse ignored", int'(ext_pend), 0);
    // R2: same pulse placed in a phase-2 interval is captured
    while (ph2 != 1'b1) tick();
    ext_pin = 1; tick(); ext_pin = 0;
    ticks(6);
    check("R2 phase-2 pulse captured", int'(ext_pend), 1);

    // R9 R10: both pending, hold, priority, acknowledge sequence
    do_reset();
    ext_en = 1;
    ticks(2);
    ext_pin = 1; nmi_pin = 1;
    ticks(4);
    ext_pin = 0; nmi_pin = 0;
    ticks(20);
    check("R9 ext held", int'(ext_pend), 1);
    check("R9 nmi held", int'(nmi_pend), 1);
    check("R10 nmi first", int'(svc_nmi), 1);
    check("R10 nmi vector", int'(svc_vec), int'(NMI_V));
    nmi_ack = 1; tick(); nmi_ack = 0;
    ticks(2);
    check("R9 nmi cleared", int'(nmi_pend), 0);
    check("R10 ext vector next", int'(svc_vec), int'(EXT_V));
    check("R10 ext request", int'(svc_req), 1);
    check("R10 ext not nmi", int'(svc_nmi), 0);
    ext_ack = 1; tick(); ext_ack = 0;
    ticks(2);
    check("R9 ext cleared", int'(ext_pend), 0);
    check("R10 no request", int'(svc_req), 0);
    check("R10 idle vector", int'(svc_vec), 0);

    // R9: new edge during a held acknowledge still shows the flag once
    do_reset();
    ext_ack = 1;
    ticks(2);
    pend_cnt = 0;
    ext_pin = 1;
    ticks(4);
    ext_pin = 0;
    ticks(8);
    ext_ack = 0;
    check("R9 set wins over ack", pend_cnt, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule